// File: doc/BRIEF.md
# Time-Division Crossbar Switch

This block connects seven 10-bit ports to seven 10-bit outputs. It does not use a private multiplexer for each output. Instead, one shared selector visits the inputs in a fixed rotation, one input per core clock. It sends the chosen word into a serial stream. Every output lane keeps its own seven-entry shift register of that stream. When a frame ends, the lane's output register takes the entry that holds the sample from its chosen source.

A lane's route is set by its 3-bit source select. A value of 0 to 6 names an input channel. A value of 7 makes the lane output zero. Several lanes may name the same source, so one input can be broadcast to many outputs.

The outputs change only at frame rate, which is once every seven core clocks. The user must therefore hold each port word steady for a full frame. Under that condition, a new input value reaches the output one frame plus one core cycle later.

A small sequencer controls the timing. It has two states:
- ST_FILL is entered at reset and lasts while the first frame of samples is gathered.
- ST_RUN is entered from ST_FILL on the cycle the channel counter reads 6, and the sequencer then stays there until reset.

In ST_RUN, the frame strobe is raised in each cycle where the counter reads 0.

Top module: `tdm_xbar`

## Requirements
- R1: A channel counter steps 0,1,…,6 and wraps to 0. At each core clock edge the shared selector samples the input channel whose number equals the counter.
- R2: `frame_strobe` is low during reset and during the first seven cycles after reset. It first goes high in the cycle after the seventh clock edge and is then high for exactly one cycle in every seven.
- R3: Each lane's shift register is seven entries deep and moves one position per clock. When the strobe is high, entry 6−s holds the sample of channel s from the frame just completed.
- R4: On the clock edge that ends a strobe cycle, each lane's output loads the word of the channel named by its select (0 to 6). The input value applied at the start of a frame appears at the outputs one frame plus one cycle later. Channel 0 is sampled on the loading edge itself, so it belongs to the next frame.
- R5: Between loading edges, every output holds its value, whatever the inputs do.
- R6: A select value of 7 makes that lane's output zero at the next load.
- R7: A select change made mid-frame has no effect on the output until the next loading edge. Only the select value present in the strobe cycle is used.
- R8: During the active-low asynchronous reset, all outputs are zero and the strobe is low.
- R9: Lanes route independently of one another. Any number of lanes may name the same source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | 70 | Seven 10-bit input words; channel i in bits [10i+9:10i] |
| route_sel | input | 21 | Seven 3-bit source selects; lane i in bits [3i+2:3i] |
| port_out | output | 70 | Seven 10-bit output words; lane i in bits [10i+9:10i] |
| frame_strobe | output | 1 | High in the cycle before each output load |

## Verification
The embedded properties check the following on every cycle:
- the counter range, step and wrap;
- the spacing of the strobe and its silence while the first frame fills;
- the one-position shift of each lane register;
- that outputs hold between loads;
- the zero result for select 7.

Some behaviours can only be shown by the bench scenarios, because each needs a value that travelled through the whole frame. These are:
- which channel word a given tap delivers;
- the exact one-frame-plus-one latency, including the split of the first frame after an input change;
- broadcast routing;
- the fact that a mid-frame select change is ignored.

// File: rtl/tdm_xbar_pkg.sv
package tdm_xbar_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/tdm_xbar_seq.sv
module tdm_xbar_seq
    import tdm_xbar_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] chan,
    output logic             frame_load
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_CH - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] chan_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (chan_q == LAST) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // channel counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              chan_q <= '0;
        else if (chan_q == LAST) chan_q <= '0;
        else                     chan_q <= chan_q + 1'b1;
    end

    // outputs
    always_comb begin
        chan       = chan_q;
        frame_load = 1'b0;
        unique case (state_q)
            ST_FILL: frame_load = 1'b0;
            ST_RUN:  frame_load = (chan_q == '0);
        endcase
    end

    p_chan_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chan <= LAST);
    p_chan_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chan == LAST) |=> (chan == '0));
    p_chan_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chan != LAST) |=> (chan == $past(chan) + 1'b1));
    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> !frame_load);
    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !frame_load);
endmodule

// File: rtl/tdm_xbar_inmux.sv
module tdm_xbar_inmux #(
    parameter int NUM_CH = 7,
    parameter int DATA_W = 10,
    parameter int CNT_W  = 3
) (
    input  logic [NUM_CH*DATA_W-1:0] bus_in,
    input  logic [CNT_W-1:0]         chan,
    output logic [DATA_W-1:0]        sample
);
    always_comb begin
        sample = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(chan) == i) sample = bus_in[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/tdm_xbar_lane.sv
module tdm_xbar_lane #(
    parameter int NUM_CH = 7,
    parameter int DATA_W = 10,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample,
    input  logic              load,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] lane_out
);
    logic [DATA_W-1:0] sr [NUM_CH];
    logic [DATA_W-1:0] tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CH; k++) sr[k] <= '0;
        end else begin
            sr[0] <= sample;
            for (int k = 1; k < NUM_CH; k++) sr[k] <= sr[k-1];
        end
    end

    // entry NUM_CH-1-s carries channel s when the strobe is high
    always_comb begin
        tap = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (int'(sel) == NUM_CH - 1 - k) tap = sr[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lane_out <= '0;
        else if (load) lane_out <= tap;
    end

    for (genvar k = 1; k < NUM_CH; k++) begin : g_chk
        p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
            sr[k] == $past(sr[k-1]));
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lane_out));
    p_zero_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && int'(sel) >= NUM_CH) |=> (lane_out == '0));
endmodule

// File: rtl/tdm_xbar.sv
module tdm_xbar #(
    parameter  int NUM_PORTS = 7,
    parameter  int DATA_W    = 10,
    localparam int CNT_W     = $clog2(NUM_PORTS),
    localparam int SEL_W     = $clog2(NUM_PORTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*DATA_W-1:0] port_in,
    input  logic [NUM_PORTS*SEL_W-1:0]  route_sel,
    output logic [NUM_PORTS*DATA_W-1:0] port_out,
    output logic                       frame_strobe
);
    logic [CNT_W-1:0]  chan;
    logic              load;
    logic [DATA_W-1:0] stream;

    tdm_xbar_seq #(.NUM_CH(NUM_PORTS), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan       (chan),
        .frame_load (load)
    );

    tdm_xbar_inmux #(.NUM_CH(NUM_PORTS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_mux (
        .bus_in (port_in),
        .chan   (chan),
        .sample (stream)
    );

    for (genvar l = 0; l < NUM_PORTS; l++) begin : g_lane
        tdm_xbar_lane #(.NUM_CH(NUM_PORTS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample   (stream),
            .load     (load),
            .sel      (route_sel[l*SEL_W +: SEL_W]),
            .lane_out (port_out[l*DATA_W +: DATA_W])
        );
    end

    assign frame_strobe = load;
endmodule

// File: tb/sim_tdm_xbar.sv
`timescale 1ns/1ps
module sim_tdm_xbar;
    localparam int NP = 7;
    localparam int DW = 10;
    localparam int SW = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NP*DW-1:0]    pin = '0;
    logic [NP*SW-1:0]    psel = '0;
    logic [NP*DW-1:0]    pout;
    logic                strb;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tdm_xbar u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_in      (pin),
        .route_sel    (psel),
        .port_out     (pout),
        .frame_strobe (strb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lane(input logic [NP*DW-1:0] v, input int i);
        return int'(v[i*DW +: DW]);
    endfunction

    // behavioural reference model
    int             m_ch = 0;
    int             m_edges = 0;
    logic [DW-1:0]  m_hist[$];
    logic [DW-1:0]  m_out[NP];
    bit             m_strb = 1'b0;

    initial for (int l = 0; l < NP; l++) m_out[l] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ch = 0; m_edges = 0; m_hist.delete(); m_strb = 1'b0;
            for (int l = 0; l < NP; l++) m_out[l] = '0;
        end else begin
            if (m_strb) begin
                for (int l = 0; l < NP; l++) begin
                    int s;
                    s = int'(psel[l*SW +: SW]);
                    m_out[l] = (s < NP) ? m_hist[m_hist.size() - NP + s] : '0;
                end
            end
            m_hist.push_back(pin[m_ch*DW +: DW]);
            if (m_hist.size() > NP) void'(m_hist.pop_front());
            m_edges++;
            m_ch = (m_ch + 1) % NP;
            m_strb = (m_edges >= NP) && (m_ch == 0);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(strb == m_strb, "R2 strobe vs model", int'(strb), int'(m_strb));
            for (int l = 0; l < NP; l++)
                chk(lane(pout, l) == int'(m_out[l]), "R4 lane vs model",
                    lane(pout, l), int'(m_out[l]));
        end
    end

    task automatic apply(input int seed);
        for (int i = 0; i < NP; i++) pin[i*DW +: DW] = DW'((seed*37 + i*101 + 5) & 10'h3ff);
    endtask

    task automatic wait_load();
        do @(negedge clk); while (!strb);
        @(negedge clk);
    endtask

    task automatic settle();
        wait_load();
        wait_load();
    endtask

    task automatic set_sel(input int l, input int v);
        psel[l*SW +: SW] = SW'(v);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [NP*DW-1:0] snap, old_in;
        int k;

        repeat (3) @(negedge clk);
        // R8: reset state
        chk(pout == '0, "R8 outputs zero in reset", int'(pout != '0), 0);
        chk(strb == 1'b0, "R8 strobe low in reset", int'(strb), 0);
        rst_n = 1'b1;

        // R2: first strobe after seven edges, then period seven
        k = 0;
        do begin @(negedge clk); k++; end while (!strb && k < 20);
        chk(k == 7, "R2 first strobe position", k, 7);
        k = 0;
        do begin @(negedge clk); k++; end while (!strb && k < 20);
        chk(k == 7, "R2 strobe period", k, 7);

        // R1: identity routing
        for (int l = 0; l < NP; l++) set_sel(l, l);
        apply(1);
        settle();
        for (int l = 0; l < NP; l++)
            chk(lane(pout, l) == lane(pin, l), "R1 identity route", lane(pout, l), lane(pin, l));

        // R4: latency, channel 0 of the first frame after a change is still old
        apply(6);
        settle();
        old_in = pin;
        apply(7);
        wait_load();
        chk(lane(pout, 0) == lane(old_in, 0), "R4 ch0 split frame", lane(pout, 0), lane(old_in, 0));
        chk(lane(pout, 3) == lane(pin, 3), "R4 ch3 new in first load", lane(pout, 3), lane(pin, 3));
        wait_load();
        chk(lane(pout, 0) == lane(pin, 0), "R4 ch0 after full frame", lane(pout, 0), lane(pin, 0));

        // R3: reversed routing exercises every tap position
        for (int l = 0; l < NP; l++) set_sel(l, NP - 1 - l);
        apply(2);
        settle();
        for (int l = 0; l < NP; l++)
            chk(lane(pout, l) == lane(pin, NP-1-l), "R3 reverse route", lane(pout, l), lane(pin, NP-1-l));

        // R9: broadcast of channel 4
        for (int l = 0; l < NP; l++) set_sel(l, 4);
        apply(3);
        settle();
        for (int l = 0; l < NP; l++)
            chk(lane(pout, l) == lane(pin, 4), "R9 broadcast", lane(pout, l), lane(pin, 4));

        // R6: select 7 zeroes lane 2, other lanes keep routing
        for (int l = 0; l < NP; l++) set_sel(l, l);
        set_sel(2, 7);
        apply(4);
        settle();
        chk(lane(pout, 2) == 0, "R6 select seven gives zero", lane(pout, 2), 0);
        chk(lane(pout, 5) == lane(pin, 5), "R6 neighbour lane unaffected", lane(pout, 5), lane(pin, 5));

        // R5: outputs hold while inputs change mid-frame
        set_sel(2, 2);
        settle();
        snap = pout;
        apply(5);
        do begin
            @(negedge clk);
            chk(pout == snap, "R5 hold between loads", int'(pout != snap), 0);
        end while (!strb);

        // R7: mid-frame select change waits for the boundary
        settle();
        snap = pout;
        for (int l = 0; l < NP; l++) set_sel(l, NP - 1 - l);
        do begin
            @(negedge clk);
            chk(pout == snap, "R7 select change deferred", int'(pout != snap), 0);
        end while (!strb);
        @(negedge clk);
        chk(lane(pout, 1) == lane(pin, 5), "R7 new select at boundary", lane(pout, 1), lane(pin, 5));

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule